// File: doc/BRIEF.md
# Forward 9/7 Lifting Wavelet Datapath

This block computes the one-dimensional forward 9/7 wavelet transform of a line of samples with the lifting method. Each accepted transfer carries one pair: the even-indexed sample and the following odd-indexed sample of the line, on two separate ports. The pair passes through four chained lifting steps, one per pipeline stage: predict, update, predict, update. A scaling stage follows, and one low-pass and one high-pass coefficient come out together for every pair that went in.

A start-of-line flag and an end-of-line flag travel with each pair. They select symmetric extension. At the last pair of a line the missing right neighbour is replaced by the pair's own value. At the first pair the missing left neighbour is replaced the same way. The two predict stages each hold one pair until its right neighbour arrives. Pairs may therefore come with idle cycles between them, and consecutive lines may follow each other with no gap.

Top module: `lift97_fwd`

## Requirements
- R1: While `rst` is high, and after it until the first pair is accepted, `out_valid` is low. Pairs offered during reset never produce an output.
- R2: Each cycle with `in_valid` high yields exactly one cycle with `out_valid` high, with results in input order. `out_sol` and `out_eol` repeat the flags of that pair.
- R3: High-pass path, with pairs indexed i inside a line: d1[i] = odd[i] + A*(even[i] + even[i+1]), then d2[i] = d1[i] + G*(s1[i] + s1[i+1]). At the end-of-line pair, even[i+1] is taken as even[i] and s1[i+1] as s1[i]. A = -25987 and G = 14466 in signed Q2.14.
- R4: Low-pass path: s1[i] = even[i] + B*(d1[i-1] + d1[i]), then s2[i] = s1[i] + D*(d2[i-1] + d2[i]). At the start-of-line pair, d1[i-1] is taken as d1[i] and d2[i-1] as d2[i]. B = -868 and D = 7266 in Q2.14.
- R5: Working values are 20-bit two's complement, and input samples are sign-extended to that width. Each coefficient product is formed from the 21-bit sum, then 8192 is added, the result is shifted right arithmetically by 14, and the low 20 bits are kept. Every addition wraps to 20 bits.
- R6: With SWAP_SCALE = 0, out_low = s2 scaled by 18835 and out_high = d2 scaled by 14252, both rounded as in R5. With SWAP_SCALE = 1 the two factors are exchanged.
- R7: Idle cycles between pairs of the same line do not change any output value.
- R8: A line of a single pair, with both flags set on it, uses the mirror rule on both sides.
- R9: When a start-of-line pair directly follows an end-of-line pair, no value from the earlier line affects the later one.
- R10: A pair captured at clock edge k appears on the outputs after edge k+6, provided the next pair of its line is captured at edge k+1 or the pair carries the end-of-line flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample pair is offered this cycle |
| in_even | input | 16 | Even-indexed sample, signed |
| in_odd | input | 16 | Odd-indexed sample, signed |
| in_sol | input | 1 | The pair is the first of its line |
| in_eol | input | 1 | The pair is the last of its line |
| out_valid | output | 1 | A coefficient pair is presented |
| out_low | output | 20 | Scaled low-pass coefficient, signed |
| out_high | output | 20 | Scaled high-pass coefficient, signed |
| out_sol | output | 1 | Start-of-line flag of the result |
| out_eol | output | 1 | End-of-line flag of the result |

## Verification
The bench drives several kinds of line. An all-zero line exposes any bias from rounding. A constant line should drive the high-pass output to about zero, so it shows whether the predict and update coefficients cancel correctly. A ramp, when compared with its mirror-extended model, shows whether the edge samples are handled. Lines that alternate between full-scale extremes exercise the guard bits and the 20-bit wrap. Random lines with and without idle gaps separate value errors from errors in holding and timing. Lines of one and two pairs, and lines presented back to back, test the mirror rule and the isolation between lines. A second instance with the scale factors exchanged shows that the parameter selects the right factor for each output.

// File: rtl/lift97_fwd.sv
module lift97_fwd #(
  parameter int DW         = 16,
  parameter int GUARD      = 4,
  parameter int CW         = 16,
  parameter int FRAC       = 14,
  parameter int C_ALPHA    = -25987,
  parameter int C_BETA     = -868,
  parameter int C_GAMMA    = 14466,
  parameter int C_DELTA    = 7266,
  parameter int C_K        = 18835,
  parameter int C_KINV     = 14252,
  parameter bit SWAP_SCALE = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic signed [DW-1:0]        in_even,
  input  logic signed [DW-1:0]        in_odd,
  input  logic                        in_sol,
  input  logic                        in_eol,
  output logic                        out_valid,
  output logic signed [DW+GUARD-1:0]  out_low,
  output logic signed [DW+GUARD-1:0]  out_high,
  output logic                        out_sol,
  output logic                        out_eol
);
  localparam int W  = DW + GUARD;
  localparam int PW = W + 1 + CW;
  localparam int KL = SWAP_SCALE ? C_KINV : C_K;
  localparam int KH = SWAP_SCALE ? C_K : C_KINV;

  typedef logic signed [W-1:0] word_t;
  typedef logic signed [W:0]   wide_t;

  function automatic wide_t pair_sum(input word_t x, input word_t y);
    return wide_t'(x) + wide_t'(y);
  endfunction

  function automatic word_t lmul(input wide_t x, input int c);
    logic signed [CW-1:0] cc;
    logic signed [PW-1:0] xe, ce, p;
    cc = CW'(c);
    xe = PW'(x);
    ce = PW'(cc);
    p  = xe * ce + (PW'(1) <<< (FRAC - 1));
    return word_t'(p >>> FRAC);
  endfunction

  // stage 1: first predict, holds one pair until its right neighbour arrives
  logic  a_v, a_sol, a_eol;
  word_t a_e, a_o;
  logic  fire_a;
  word_t a_nxt, d1;

  assign fire_a = a_v & (a_eol | in_valid);
  assign a_nxt  = a_eol ? a_e : word_t'(in_even);
  assign d1     = a_o + lmul(pair_sum(a_e, a_nxt), C_ALPHA);

  // stage 2: first update, keeps the previous d1
  logic  b_v, b_sol, b_eol;
  word_t b_e, b_d, b_dprev;
  word_t s1;

  assign s1 = b_e + lmul(pair_sum(b_sol ? b_d : b_dprev, b_d), C_BETA);

  logic  c_v, c_sol, c_eol;
  word_t c_s, c_d;

  // stage 3: second predict, same holding scheme as stage 1
  logic  h_v, h_sol, h_eol;
  word_t h_s, h_d;
  logic  fire_h;
  word_t h_nxt, d2;

  assign fire_h = h_v & (h_eol | c_v);
  assign h_nxt  = h_eol ? h_s : c_s;
  assign d2     = h_d + lmul(pair_sum(h_s, h_nxt), C_GAMMA);

  // stage 4: second update
  logic  d_v, d_sol, d_eol;
  word_t d_s, d_d, d_dprev;
  word_t s2;

  assign s2 = d_s + lmul(pair_sum(d_sol ? d_d : d_dprev, d_d), C_DELTA);

  logic  e_v, e_sol, e_eol;
  word_t e_s, e_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_v       <= 1'b0;
      b_v       <= 1'b0;
      c_v       <= 1'b0;
      h_v       <= 1'b0;
      d_v       <= 1'b0;
      e_v       <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (in_valid)    a_v <= 1'b1;
      else if (fire_a) a_v <= 1'b0;
      b_v <= fire_a;
      c_v <= b_v;
      if (c_v)         h_v <= 1'b1;
      else if (fire_h) h_v <= 1'b0;
      d_v       <= fire_h;
      e_v       <= d_v;
      out_valid <= e_v;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      a_e   <= word_t'(in_even);
      a_o   <= word_t'(in_odd);
      a_sol <= in_sol;
      a_eol <= in_eol;
    end
    if (fire_a) begin
      b_e   <= a_e;
      b_d   <= d1;
      b_sol <= a_sol;
      b_eol <= a_eol;
    end
    if (b_v) begin
      b_dprev <= b_d;
      c_s     <= s1;
      c_d     <= b_d;
      c_sol   <= b_sol;
      c_eol   <= b_eol;
    end
    if (c_v) begin
      h_s   <= c_s;
      h_d   <= c_d;
      h_sol <= c_sol;
      h_eol <= c_eol;
    end
    if (fire_h) begin
      d_s   <= h_s;
      d_d   <= d2;
      d_sol <= h_sol;
      d_eol <= h_eol;
    end
    if (d_v) begin
      d_dprev <= d_d;
      e_s     <= s2;
      e_d     <= d_d;
      e_sol   <= d_sol;
      e_eol   <= d_eol;
    end
    if (e_v) begin
      out_low  <= lmul(wide_t'(e_s), KL);
      out_high <= lmul(wide_t'(e_d), KH);
      out_sol  <= e_sol;
      out_eol  <= e_eol;
    end
  end
endmodule

// File: rtl/lift97_fwd_chk.sv
module lift97_fwd_chk #(
  parameter int W = 20
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                out_valid,
  input logic                out_sol,
  input logic                out_eol,
  input logic signed [W-1:0] out_low,
  input logic signed [W-1:0] out_high
);
  logic [3:0] pending;
  logic       line_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= '0;
      line_open <= 1'b0;
    end else begin
      pending <= pending + 4'(in_valid) - 4'(out_valid);
      if (out_valid) line_open <= !out_eol;
    end
  end

  assert_quiet_in_reset_R1: assert property (@(posedge clk) rst |=> !out_valid);

  assert_no_phantom_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> pending != 4'd0);

  assert_bounded_fill_R2: assert property (@(posedge clk) disable iff (rst)
    pending <= 4'd8);

  assert_line_framing_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sol == !line_open));

  assert_defined_result_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown({out_low, out_high, out_sol, out_eol}));
endmodule

bind lift97_fwd lift97_fwd_chk #(.W($bits(out_low))) chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_sol(out_sol), .out_eol(out_eol), .out_low(out_low), .out_high(out_high)
);

// File: tb/lift97_fwd_test.sv
module lift97_fwd_test;
  localparam int DW = 16;
  localparam int W  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_even = '0, in_odd = '0;
  logic in_sol = 1'b0, in_eol = 1'b0;
  logic out_valid, out_sol, out_eol;
  logic signed [W-1:0] out_low, out_high;
  logic sw_valid, sw_sol, sw_eol;
  logic signed [W-1:0] sw_low, sw_high;

  always #5 clk = ~clk;

  lift97_fwd uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_even(in_even), .in_odd(in_odd),
    .in_sol(in_sol), .in_eol(in_eol), .out_valid(out_valid), .out_low(out_low),
    .out_high(out_high), .out_sol(out_sol), .out_eol(out_eol));

  lift97_fwd #(.SWAP_SCALE(1'b1)) uut_sw (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_even(in_even), .in_odd(in_odd),
    .in_sol(in_sol), .in_eol(in_eol), .out_valid(sw_valid), .out_low(sw_low),
    .out_high(sw_high), .out_sol(sw_sol), .out_eol(sw_eol));

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [2*W+1:0] expq[$];
  logic [2*W+1:0] swq[$];
  int             latq[$];
  string          tagq[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint wrap(longint v);
    logic signed [W-1:0] t;
    t = v[W-1:0];
    return longint'(t);
  endfunction

  function automatic longint mulm(longint s, longint c);
    return wrap((s * c + 8192) >>> 14);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // pat: 0 zero, 1 constant, 2 ramp, 3 full-scale alternation, 4 random
  task automatic send_line(int n, int pat, bit gaps, string tag);
    longint e[32], o[32], d1[32], s1[32], d2[32], s2[32];
    for (int i = 0; i < n; i++) begin
      case (pat)
        0: begin e[i] = 0; o[i] = 0; end
        1: begin e[i] = 1000; o[i] = 1000; end
        2: begin e[i] = 1400 * i - 5000; o[i] = 1400 * i - 4300; end
        3: begin e[i] = 32767; o[i] = -32768; end
        default: begin
          e[i] = longint'(shortint'($urandom));
          o[i] = longint'(shortint'($urandom));
        end
      endcase
    end
    for (int i = 0; i < n; i++)
      d1[i] = wrap(o[i] + mulm(e[i] + ((i == n-1) ? e[i] : e[i+1]), -25987));
    for (int i = 0; i < n; i++)
      s1[i] = wrap(e[i] + mulm(((i == 0) ? d1[i] : d1[i-1]) + d1[i], -868));
    for (int i = 0; i < n; i++)
      d2[i] = wrap(d1[i] + mulm(s1[i] + ((i == n-1) ? s1[i] : s1[i+1]), 14466));
    for (int i = 0; i < n; i++)
      s2[i] = wrap(s1[i] + mulm(((i == 0) ? d2[i] : d2[i-1]) + d2[i], 7266));
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] lo, hi, lsw, hsw;
      if (gaps && i > 0) idle(1 + ($urandom % 3));
      @(negedge clk);
      in_valid = 1'b1;
      in_even  = DW'(e[i]);
      in_odd   = DW'(o[i]);
      in_sol   = (i == 0);
      in_eol   = (i == n-1);
      lo  = W'(mulm(s2[i], 18835));
      hi  = W'(mulm(d2[i], 14252));
      lsw = W'(mulm(s2[i], 14252));
      hsw = W'(mulm(d2[i], 18835));
      expq.push_back({(i == 0), (i == n-1), lo, hi});
      swq.push_back({(i == 0), (i == n-1), lsw, hsw});
      latq.push_back(gaps ? -1 : cyc + 7);
      tagq.push_back(tag);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2 unexpected output", 1, 0);
      end else begin
        logic [2*W+1:0] ex, es;
        int    lat;
        string tg;
        ex  = expq.pop_front();
        es  = swq.pop_front();
        lat = latq.pop_front();
        tg  = tagq.pop_front();
        check(out_high == $signed(ex[W-1:0]), {"R3 high ", tg}, out_high, $signed(ex[W-1:0]));
        check(out_low == $signed(ex[2*W-1:W]), {"R4 low ", tg}, out_low, $signed(ex[2*W-1:W]));
        check({out_sol, out_eol} == ex[2*W+1:2*W], {"R2 flags ", tg},
              {out_sol, out_eol}, ex[2*W+1:2*W]);
        check(sw_valid && sw_low == $signed(es[2*W-1:W]) && sw_high == $signed(es[W-1:0]),
              {"R6 swapped scale ", tg}, sw_low, $signed(es[2*W-1:W]));
        if (lat >= 0) check(cyc == lat, {"R10 latency ", tg}, cyc, lat);
      end
    end
  end

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // pairs offered during reset must be dropped (R1)
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_even  = 16'sd1234;
      in_odd   = -16'sd321;
      in_sol   = 1'b1;
      in_eol   = 1'b1;
      check(!out_valid, "R1 valid during reset", out_valid, 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(!out_valid && !sw_valid, "R1 valid after reset", out_valid, 0);
    end

    send_line(6, 0, 1'b0, "R3 zero line");
    send_line(8, 1, 1'b0, "R4 constant line");
    send_line(8, 2, 1'b0, "R9 ramp back to back");
    idle(3);
    send_line(5, 3, 1'b0, "R5 full-scale alternation");
    send_line(1, 4, 1'b0, "R8 single pair");
    send_line(1, 2, 1'b0, "R8 single pair again");
    send_line(2, 4, 1'b0, "R8 two pairs");
    send_line(10, 4, 1'b1, "R7 random with gaps");
    send_line(16, 4, 1'b0, "R5 random");
    send_line(7, 2, 1'b1, "R7 ramp with gaps");
    idle(20);
    check(expq.size() == 0, "R2 all results returned", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule